// File: doc/BRIEF.md
# Length-Partitioned Huffman Symbol Decoder

This block turns a serial stream of prefix-coded bits back into 4-bit symbols. It does not walk a code tree. Arriving bits are appended to a left-aligned bit window. Once at least six bits (the longest codeword) are buffered, a length decoder reads the leading bits and raises one line of a one-hot length select. Only the table that holds codewords of that length is then searched. On a hit the symbol is emitted with a one-cycle valid pulse, the window drops exactly the bits of that codeword, and the controller starts over. A leading pattern that has no entry in its table latches a sticky error, and decoding stops until reset.

The alphabet has 15 symbols, values 0 to 14. Value 15 is not coded. The codebook is fixed and canonical, and the number of leading ones fixes the codeword length. The controller is a four-state machine:

- FILL waits for enough bits.
- SELECT registers the one-hot length.
- MATCH searches the chosen table.
- HALT is entered after an unmatched prefix.

The transitions are:

- FILL to SELECT when the window count reaches six.
- SELECT to MATCH, always.
- MATCH to FILL on a hit.
- MATCH to HALT on a miss.
- HALT stays in HALT until reset.

Each codeword therefore takes three cycles, so the source must leave at least two idle cycles between bits.

Top module: `huff_partdec`

## Requirements
- R1: Codebook, sent MSB first. Symbol 0 is `0` (1 bit). Symbols 1..4 are `10` followed by (s-1) in 2 bits (4 bits). Symbols 5..8 are `110` followed by (s-5) in 2 bits (5 bits). Symbols 9..12 are `1110` followed by (s-9) in 2 bits (6 bits). Symbols 13..14 are `11110` followed by (s-13) in 1 bit (6 bits). Every codeword decodes to its symbol on `sym_data`.
- R2: The length select is one-hot during every table search. It is chosen by the count of leading ones: none selects length 1, one selects length 4, two selects length 5, and three or more select length 6.
- R3: A search starts only when at least 6 bits are buffered. Fewer than 6 leftover bits never produce a symbol.
- R4: Each decoded codeword gives exactly one `sym_valid` pulse, one cycle wide. Symbols appear in stream order.
- R5: A hit removes exactly the codeword's length from the window, and the following bits are kept for the next codeword. This holds across any mix of lengths.
- R6: A window that starts with five ones has no entry in the length-6 table. It sets `dec_error`, emits no symbol, and the error stays set and the output stays silent until reset.
- R7: Synchronous active-high `rst` clears the window, the bit count, the length select, `sym_valid`, `sym_data` and `dec_error`.
- R8: With input bits at most one per three cycles, the buffered count never exceeds the 12-bit window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_bit | input | 1 | Serial coded bit |
| code_vld | input | 1 | Strobe: `code_bit` is valid this cycle |
| sym_data | output | 4 | Decoded symbol |
| sym_valid | output | 1 | Match status, a one-cycle pulse per decoded symbol |
| dec_error | output | 1 | Sticky flag for an unmatched prefix |

## Verification
The hardest situation to reach is a window that holds codewords of different lengths back to back while new bits keep arriving. In that state a wrong shift amount or a lost bit shows up only several symbols later. The stimulus streams a fixed vector table that covers every symbol, a long pseudo-random sequence, and a run of 1-bit codewords. Each stream ends with exactly five padding zeros, so every real codeword is decoded and no phantom symbol appears. Directed cases then stop the stream at five buffered bits to show that nothing is decoded, and inject the five-ones prefix to check the sticky error.

// File: rtl/huff_pkg.sv
package huff_pkg;
    localparam int CODE_W = 6;
    localparam int SYM_W  = 4;
    localparam int NSYM   = 15;

    typedef enum logic [1:0] {
        ST_FILL   = 2'd0,
        ST_SELECT = 2'd1,
        ST_MATCH  = 2'd2,
        ST_HALT   = 2'd3
    } dec_state_t;

    // Codeword length of symbol s
    function automatic int code_len(input int s);
        if (s == 0)       return 1;
        else if (s <= 4)  return 4;
        else if (s <= 8)  return 5;
        else              return 6;
    endfunction

    // Codeword of symbol s, left aligned, unused low bits zero
    function automatic logic [CODE_W-1:0] code_bits(input int s);
        logic [CODE_W-1:0] c;
        if (s == 0)       c = 6'b000000;
        else if (s <= 4)  c = {2'b10,   2'(s - 1), 2'b00};
        else if (s <= 8)  c = {3'b110,  2'(s - 5), 1'b0};
        else if (s <= 12) c = {4'b1110, 2'(s - 9)};
        else              c = {5'b11110, 1'(s - 13)};
        return c;
    endfunction

    // Mask selecting the top k bits of a window
    function automatic logic [CODE_W-1:0] top_mask(input int k);
        logic [CODE_W-1:0] m;
        for (int i = 0; i < CODE_W; i++) m[CODE_W-1-i] = (i < k);
        return m;
    endfunction

    // Codeword length implied by the leading ones of a window
    function automatic int lead_len(input logic [CODE_W-1:0] w);
        int  ones;
        logic run;
        ones = 0;
        run  = 1'b1;
        for (int i = CODE_W - 1; i >= 0; i--) begin
            if (run && w[i]) ones++;
            else             run = 1'b0;
        end
        if (ones == 0)      return 1;
        else if (ones == 1) return 4;
        else if (ones == 2) return 5;
        else                return 6;
    endfunction
endpackage

// File: rtl/huff_collector.sv
module huff_collector #(
    parameter int CAP  = 12,
    parameter int SHW  = 3,
    localparam int CNTW = $clog2(CAP + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bit_in,
    input  logic            bit_vld,
    input  logic [SHW-1:0]  shift_amt,
    output logic [CAP-1:0]  win,
    output logic [CNTW-1:0] cnt
);
    logic [CAP-1:0]  win_nxt;
    logic [CNTW-1:0] cnt_nxt;
    logic [CNTW-1:0] remain;

    always_comb begin
        remain  = cnt - CNTW'(shift_amt);
        win_nxt = win << shift_amt;
        cnt_nxt = remain;
        if (bit_vld && (int'(remain) < CAP)) begin
            for (int i = 0; i < CAP; i++) begin
                if (int'(remain) == CAP - 1 - i) win_nxt[i] = bit_in;
            end
            cnt_nxt = remain + CNTW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win <= '0;
            cnt <= '0;
        end else begin
            win <= win_nxt;
            cnt <= cnt_nxt;
        end
    end
endmodule

// File: rtl/huff_len_decode.sv
module huff_len_decode
    import huff_pkg::*;
#(
    parameter int MAXLEN = CODE_W
) (
    input  logic [MAXLEN-1:0] win_top,
    output logic [MAXLEN-1:0] len_oh
);
    always_comb begin
        int l;
        l = lead_len(CODE_W'(win_top));
        len_oh = '0;
        for (int k = 1; k <= MAXLEN; k++) begin
            if (k == l) len_oh[k-1] = 1'b1;
        end
    end
endmodule

// File: rtl/huff_sym_lookup.sv
module huff_sym_lookup
    import huff_pkg::*;
#(
    parameter int MAXLEN = CODE_W,
    parameter int SYMW   = SYM_W
) (
    input  logic [MAXLEN-1:0] win_top,
    input  logic [MAXLEN-1:0] sel,
    output logic              hit,
    output logic [SYMW-1:0]   sym
);
    logic [MAXLEN-1:0] tab_hit;
    logic [SYMW-1:0]   tab_sym [MAXLEN];

    for (genvar k = 1; k <= MAXLEN; k++) begin : g_table
        logic            hk;
        logic [SYMW-1:0] sk;
        always_comb begin
            hk = 1'b0;
            sk = '0;
            for (int s = 0; s < NSYM; s++) begin
                if (code_len(s) == k &&
                    ((CODE_W'(win_top) & top_mask(k)) == code_bits(s))) begin
                    hk = 1'b1;
                    sk = SYMW'(s);
                end
            end
        end
        assign tab_hit[k-1] = hk & sel[k-1];
        assign tab_sym[k-1] = sk;
    end

    always_comb begin
        hit = |tab_hit;
        sym = '0;
        for (int k = 0; k < MAXLEN; k++) begin
            if (tab_hit[k]) sym = sym | tab_sym[k];
        end
    end
endmodule

// File: rtl/huff_ctrl.sv
module huff_ctrl
    import huff_pkg::*;
#(
    parameter int MAXLEN = CODE_W,
    parameter int SYMW   = SYM_W,
    parameter int CNTW   = 4,
    parameter int SHW    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNTW-1:0]   cnt,
    input  logic [MAXLEN-1:0] len_oh,
    input  logic              hit,
    input  logic [SYMW-1:0]   sym_in,
    output logic [MAXLEN-1:0] sel_q,
    output logic [SHW-1:0]    shift_amt,
    output logic              in_match,
    output logic [SYMW-1:0]   sym_q,
    output logic              vld_q,
    output logic              err_q
);
    dec_state_t st, st_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_FILL;
        else     st <= st_nxt;
    end

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_FILL:   if (cnt >= CNTW'(MAXLEN)) st_nxt = ST_SELECT;
            ST_SELECT: st_nxt = ST_MATCH;
            ST_MATCH:  st_nxt = hit ? ST_FILL : ST_HALT;
            ST_HALT:   st_nxt = ST_HALT;
        endcase
    end

    assign in_match = (st == ST_MATCH);

    // bits consumed on a hit
    always_comb begin
        shift_amt = '0;
        if (in_match && hit) begin
            for (int k = 0; k < MAXLEN; k++) begin
                if (sel_q[k]) shift_amt = SHW'(k + 1);
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            sym_q <= '0;
            vld_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            vld_q <= 1'b0;
            unique case (st)
                ST_FILL:   ;
                ST_SELECT: sel_q <= len_oh;
                ST_MATCH: begin
                    if (hit) begin
                        sym_q <= sym_in;
                        vld_q <= 1'b1;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                ST_HALT:   ;
            endcase
        end
    end
endmodule

// File: rtl/huff_partdec.sv
module huff_partdec
    import huff_pkg::*;
#(
    parameter int MAXLEN = CODE_W,
    parameter int SYMW   = SYM_W,
    parameter int CAP    = 2 * CODE_W,
    localparam int CNTW  = $clog2(CAP + 1),
    localparam int SHW   = $clog2(MAXLEN + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            code_bit,
    input  logic            code_vld,
    output logic [SYMW-1:0] sym_data,
    output logic            sym_valid,
    output logic            dec_error
);
    logic [CAP-1:0]    win_w;
    logic [CNTW-1:0]   cnt_w;
    logic [SHW-1:0]    shift_w;
    logic [MAXLEN-1:0] oh_w;
    logic [MAXLEN-1:0] sel_w;
    logic              hit_w;
    logic [SYMW-1:0]   sym_w;
    logic              match_w;

    huff_collector #(.CAP(CAP), .SHW(SHW)) u_coll (
        .clk(clk), .rst(rst), .bit_in(code_bit), .bit_vld(code_vld),
        .shift_amt(shift_w), .win(win_w), .cnt(cnt_w)
    );

    huff_len_decode #(.MAXLEN(MAXLEN)) u_len (
        .win_top(win_w[CAP-1 -: MAXLEN]), .len_oh(oh_w)
    );

    huff_sym_lookup #(.MAXLEN(MAXLEN), .SYMW(SYMW)) u_look (
        .win_top(win_w[CAP-1 -: MAXLEN]), .sel(sel_w), .hit(hit_w), .sym(sym_w)
    );

    huff_ctrl #(.MAXLEN(MAXLEN), .SYMW(SYMW), .CNTW(CNTW), .SHW(SHW)) u_ctrl (
        .clk(clk), .rst(rst), .cnt(cnt_w), .len_oh(oh_w), .hit(hit_w),
        .sym_in(sym_w), .sel_q(sel_w), .shift_amt(shift_w), .in_match(match_w),
        .sym_q(sym_data), .vld_q(sym_valid), .err_q(dec_error)
    );
endmodule

// File: rtl/huff_partdec_chk.sv
module huff_partdec_chk #(
    parameter int MAXLEN = 6,
    parameter int CAP    = 12,
    parameter int CNTW   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              in_match,
    input logic [MAXLEN-1:0] sel,
    input logic [CNTW-1:0]   cnt,
    input logic              sym_valid,
    input logic              dec_error
);
    a_r2_sel_onehot: assert property (@(posedge clk) disable iff (rst)
        in_match |-> $countones(sel) == 1);

    a_r3_enough_bits: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> $past(cnt) >= CNTW'(MAXLEN));

    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
        sym_valid |=> !sym_valid);

    a_r6_err_sticky: assert property (@(posedge clk) disable iff (rst)
        dec_error |=> dec_error && !sym_valid);

    a_r7_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> cnt == '0 && !sym_valid && !dec_error);

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
        int'(cnt) <= CAP);
endmodule

bind huff_partdec huff_partdec_chk #(.MAXLEN(MAXLEN), .CAP(CAP), .CNTW(CNTW)) u_chk (
    .clk(clk), .rst(rst), .in_match(match_w), .sel(sel_w), .cnt(cnt_w),
    .sym_valid(sym_valid), .dec_error(dec_error)
);

// File: tb/sim_huff_partdec.sv
module sim_huff_partdec;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       code_bit = 1'b0;
    logic       code_vld = 1'b0;
    logic [3:0] sym_data;
    logic       sym_valid;
    logic       dec_error;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] got[$];

    always #10 clk = ~clk;  // 50 MHz

    huff_partdec u0 (
        .clk(clk), .rst(rst), .code_bit(code_bit), .code_vld(code_vld),
        .sym_data(sym_data), .sym_valid(sym_valid), .dec_error(dec_error)
    );

    // symbols that cover every length class in mixed order
    localparam int NV = 24;
    localparam logic [3:0] VEC [NV] = '{
        4'd0, 4'd14, 4'd1, 4'd9, 4'd5, 4'd0, 4'd12, 4'd4,
        4'd8, 4'd13, 4'd2, 4'd6, 4'd10, 4'd0, 4'd3, 4'd7,
        4'd11, 4'd0, 4'd0, 4'd14, 4'd13, 4'd9, 4'd1, 4'd5
    };

    always @(negedge clk) if (!rst && sym_valid) got.push_back(sym_data);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R1 code: returns length and left-aligned bits
    task automatic encode(input int s, output int len, output logic [5:0] bits);
        if (s == 0)       begin len = 1; bits = 6'b0; end
        else if (s < 5)   begin len = 4; bits = {2'b10, 2'(s - 1), 2'b00}; end
        else if (s < 9)   begin len = 5; bits = {3'b110, 2'(s - 5), 1'b0}; end
        else if (s < 13)  begin len = 6; bits = {4'b1110, 2'(s - 9)}; end
        else              begin len = 6; bits = {5'b11110, 1'(s - 13)}; end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        code_bit = b;
        code_vld = 1'b1;
        @(negedge clk);
        code_vld = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_sym(input int s);
        int len;
        logic [5:0] bits;
        encode(s, len, bits);
        for (int i = 0; i < len; i++) send_bit(bits[5 - i]);
    endtask

    task automatic pad_flush();
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        repeat (20) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        code_vld = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        got.delete();
    endtask

    task automatic compare_seq(input logic [3:0] exp_q[$], input string req);
        check(got.size() == exp_q.size(), {req, " count"}, got.size(), exp_q.size());
        for (int i = 0; i < exp_q.size() && i < got.size(); i++)
            check(got[i] == exp_q[i], req, got[i], exp_q[i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [3:0] exp_q[$];
        repeat (3) @(negedge clk);
        // R7: reset state
        check(sym_valid == 1'b0, "R7 sym_valid", sym_valid, 0);
        check(dec_error == 1'b0, "R7 dec_error", dec_error, 0);
        check(sym_data == 4'd0, "R7 sym_data", sym_data, 0);
        rst = 1'b0;

        // R1 R4 R5: vector table
        exp_q.delete();
        for (int i = 0; i < NV; i++) begin
            send_sym(VEC[i]);
            exp_q.push_back(VEC[i]);
        end
        pad_flush();
        compare_seq(exp_q, "R1_R5 table");
        check(dec_error == 1'b0, "R6 no error on valid stream", dec_error, 0);

        // R4 R5 R8: pseudo-random stream
        do_reset();
        exp_q.delete();
        for (int i = 0; i < 60; i++) begin
            int s;
            s = int'($urandom % 15);
            send_sym(s);
            exp_q.push_back(4'(s));
        end
        pad_flush();
        compare_seq(exp_q, "R4_R5 random");

        // R8: run of 1-bit codewords at the fastest input rate
        do_reset();
        exp_q.delete();
        for (int i = 0; i < 12; i++) begin
            send_sym(0);
            exp_q.push_back(4'd0);
        end
        pad_flush();
        compare_seq(exp_q, "R8 short codes");

        // R3: five buffered bits give nothing, the sixth releases one symbol
        do_reset();
        for (int i = 0; i < 5; i++) send_bit(1'b0);
        repeat (20) @(negedge clk);
        check(got.size() == 0, "R3 five bits", got.size(), 0);
        send_bit(1'b0);
        repeat (20) @(negedge clk);
        check(got.size() == 1, "R3 six bits", got.size(), 1);

        // R6: five leading ones, then valid codes
        do_reset();
        for (int i = 0; i < 6; i++) send_bit(i < 5 ? 1'b1 : 1'b0);
        repeat (10) @(negedge clk);
        check(dec_error == 1'b1, "R6 error set", dec_error, 1);
        check(got.size() == 0, "R6 no symbol", got.size(), 0);
        send_sym(3);
        send_sym(0);
        pad_flush();
        check(dec_error == 1'b1, "R6 error sticky", dec_error, 1);
        check(got.size() == 0, "R6 silent after error", got.size(), 0);

        // R7: reset clears the error and decoding resumes
        do_reset();
        @(negedge clk);
        check(dec_error == 1'b0, "R7 error cleared", dec_error, 0);
        exp_q.delete();
        send_sym(13);
        exp_q.push_back(4'd13);
        pad_flush();
        compare_seq(exp_q, "R7 resume");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule